// File: doc/BRIEF.md
# Fractional Serial Clock Generator

This block derives a serial-interface bit clock from a fast reference clock using a phase accumulator with a scale of 2048 per output period. On every reference cycle in which the transfer engine asserts its run input, a per-profile step value is added to an 11-bit accumulator. The serial clock changes level each time the running total passes a multiple of 1024, which gives an output frequency of `f_ref * step / 2048`. Because the step does not have to divide 2048 evenly, the half-periods may differ by one reference cycle. The average rate still follows the step exactly.

Software keeps one clock word for each of several profiles. Each word holds the step value, a double-rate select and a restart-on-start flag. The engine selects a profile, drives the idle polarity and raises the run input for the length of a transfer. While the clock runs, the block emits a one-cycle launch strobe when the clock leaves its idle level and a one-cycle latch strobe when it returns to idle. The engine maps these strobes onto the edges that each profile uses.

Top module: `spiAccClkGen`

## Requirements
- R1: A cycle with `cfgWe` high stores `cfgData` as the clock word of profile `cfgProfile`. The word has these fields: step in bits 11:0, double-rate select in bit 14, and restart-on-start in bit 15. Bits 13:12 have no effect. All words reset to zero.
- R2: While `runEn` is high, the step of the selected profile is added to the accumulator on each reference cycle. Starting from an accumulator of zero, `sclk` has changed level exactly floor(N*step/1024) times after N running cycles.
- R3: The effective step is clamped to 1024, so `sclk` never runs faster than half the reference rate. A step of zero leaves `sclk` idle, with no strobes.
- R4: When the double-rate bit is set, the step is doubled before the clamp of R3 is applied.
- R5: When the restart bit is set, the first running cycle after `runEn` rises adds the step to zero. When the bit is clear, stepping continues from the value the accumulator held when the previous run stopped.
- R6: While `runEn` is low, `sclk` equals `cpol`, both strobes stay low, and the accumulator keeps its value.
- R7: `cpol` sets the idle level of `sclk`. The active level is the inverse of `cpol`.
- R8: `launchStb` is high for exactly the one cycle in which `sclk` has just moved from idle to active. `latchStb` is high for exactly the one cycle in which `sclk` has just returned to idle. The two strobes are never high together.
- R9: `profSel` chooses which stored clock word drives the accumulator. It is sampled on every reference cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Clock word write enable |
| cfgProfile | input | PROF_W | Profile written by `cfgWe` |
| cfgData | input | 16 | Clock word: step 11:0, double-rate 14, restart 15 |
| profSel | input | PROF_W | Profile in use for the transfer |
| runEn | input | 1 | Run request from the transfer engine |
| cpol | input | 1 | Idle level of the serial clock |
| sclk | output | 1 | Serial clock |
| launchStb | output | 1 | Pulse when sclk leaves idle |
| latchStb | output | 1 | Pulse when sclk returns to idle |

## Verification
The step value is swept from 0 up past 2048 in uneven increments, with the double-rate bit both off and on and with `cpol` alternating. Every sweep point is compared with the arithmetic count floor(N*step/1024) of level changes. This sweep separates correct fractional stepping from rounding errors, and it also exercises the clamp at 1024 and the all-zero step. A split transfer, run first under a restarting profile and then under a continuing one, shows whether the accumulator resets or keeps its value across a stop. A word written with its unused bits set shows that those bits are ignored.

// File: rtl/spiAccClkPkg.sv
package spiAccClkPkg;
  localparam int ACC_W    = 11;              // 2048 steps per output period
  localparam int HALF_BIT = ACC_W - 1;       // crossing 1024 flips this bit
  localparam int FREQ_W   = 12;
  localparam int CFG_W    = 16;
  localparam int DBL_BIT  = 14;
  localparam int RST_BIT  = 15;
  localparam int STEP_W   = ACC_W;           // holds 0..1024
  localparam logic [STEP_W-1:0] STEP_MAX = STEP_W'(1 << HALF_BIT);

  typedef struct packed {
    logic              stepEn;
    logic              clrAcc;
    logic [STEP_W-1:0] step;
  } stepCtrlT;
endpackage

// File: rtl/spiAccClkCtrl.sv
module spiAccClkCtrl
  import spiAccClkPkg::*;
#(
  parameter int NPROF = 4,
  localparam int PROF_W = (NPROF > 1) ? $clog2(NPROF) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWe,
  input  logic [PROF_W-1:0] cfgProfile,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic [PROF_W-1:0] profSel,
  input  logic              runEn,
  output stepCtrlT          ctl
);
  logic [FREQ_W-1:0] freqQ [NPROF];
  logic [NPROF-1:0]  dblQ;
  logic [NPROF-1:0]  rstQ;
  logic              runPrevQ;

  // one clock word per profile
  for (genvar p = 0; p < NPROF; p++) begin : g_prof
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        freqQ[p] <= '0;
        dblQ[p]  <= 1'b0;
        rstQ[p]  <= 1'b0;
      end else if (cfgWe && (cfgProfile == PROF_W'(p))) begin
        freqQ[p] <= cfgData[FREQ_W-1:0];
        dblQ[p]  <= cfgData[DBL_BIT];
        rstQ[p]  <= cfgData[RST_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) runPrevQ <= 1'b0;
    else        runPrevQ <= runEn;
  end

  logic [FREQ_W-1:0] selFreq;
  logic              selDbl;
  logic              selRst;
  logic [FREQ_W:0]   rawStep;

  always_comb begin
    selFreq = freqQ[profSel];
    selDbl  = dblQ[profSel];
    selRst  = rstQ[profSel];
    rawStep = selDbl ? {selFreq, 1'b0} : {1'b0, selFreq};
    ctl.stepEn = runEn;
    ctl.clrAcc = runEn && !runPrevQ && selRst;
    if (rawStep >= (FREQ_W+1)'(STEP_MAX)) ctl.step = STEP_MAX;
    else                                  ctl.step = rawStep[STEP_W-1:0];
  end
endmodule

// File: rtl/spiAccClkDp.sv
module spiAccClkDp
  import spiAccClkPkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  stepCtrlT ctl,
  input  logic     cpol,
  output logic     sclk,
  output logic     launchStb,
  output logic     latchStb
);
  logic [ACC_W-1:0] accQ;
  logic             phaseQ;
  logic [ACC_W-1:0] base;
  logic [ACC_W:0]   sum;
  logic             flip;

  always_comb begin
    base = ctl.clrAcc ? '0 : accQ;
    sum  = {1'b0, base} + {1'b0, ctl.step};
    flip = sum[HALF_BIT] ^ base[HALF_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accQ      <= '0;
      phaseQ    <= 1'b0;
      launchStb <= 1'b0;
      latchStb  <= 1'b0;
    end else if (!ctl.stepEn) begin
      phaseQ    <= 1'b0;
      launchStb <= 1'b0;
      latchStb  <= 1'b0;
    end else begin
      accQ      <= sum[ACC_W-1:0];
      phaseQ    <= phaseQ ^ flip;
      launchStb <= flip && !phaseQ;
      latchStb  <= flip && phaseQ;
    end
  end

  assign sclk = cpol ^ phaseQ;
endmodule

// File: rtl/spiAccClkGen.sv
module spiAccClkGen
  import spiAccClkPkg::*;
#(
  parameter int NPROF = 4,
  localparam int PROF_W = (NPROF > 1) ? $clog2(NPROF) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWe,
  input  logic [PROF_W-1:0] cfgProfile,
  input  logic [15:0]       cfgData,
  input  logic [PROF_W-1:0] profSel,
  input  logic              runEn,
  input  logic              cpol,
  output logic              sclk,
  output logic              launchStb,
  output logic              latchStb
);
  stepCtrlT ctl;

  spiAccClkCtrl #(.NPROF(NPROF)) uCtrl (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgProfile(cfgProfile),
    .cfgData(cfgData), .profSel(profSel), .runEn(runEn), .ctl(ctl)
  );

  spiAccClkDp uDp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .cpol(cpol),
    .sclk(sclk), .launchStb(launchStb), .latchStb(latchStb)
  );
endmodule

// File: rtl/spiAccClkChk.sv
module spiAccClkChk (
  input logic clk,
  input logic rst_n,
  input logic runEn,
  input logic cpol,
  input logic sclk,
  input logic launchStb,
  input logic latchStb
);
  // R6: a cycle without run leaves the clock idle
  assert_idle_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !runEn |=> (sclk == cpol));
  // R6: no strobes follow a stopped cycle
  assert_no_strobe_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !runEn |=> (!launchStb && !latchStb));
  // R8: strobes are exclusive
  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(launchStb && latchStb));
  // R8/R7: launch marks the active level, latch marks idle
  assert_launch_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
    launchStb |-> (sclk != cpol));
  assert_latch_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    latchStb |-> (sclk == cpol));
  // R3: the clamp keeps two launches at least two cycles apart
  assert_launch_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    launchStb |=> !launchStb);
endmodule

bind spiAccClkGen spiAccClkChk uChk (
  .clk(clk), .rst_n(rst_n), .runEn(runEn), .cpol(cpol),
  .sclk(sclk), .launchStb(launchStb), .latchStb(latchStb)
);

// File: tb/sim_spiAccClkGen.sv
`timescale 1ns/1ps
module sim_spiAccClkGen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfgWe = 1'b0;
  logic [1:0] cfgProfile = '0;
  logic [15:0] cfgData = '0;
  logic [1:0] profSel = '0;
  logic       runEn = 1'b0;
  logic       cpol = 1'b0;
  logic       sclk, launchStb, latchStb;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  spiAccClkGen #(.NPROF(4)) u0 (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgProfile(cfgProfile),
    .cfgData(cfgData), .profSel(profSel), .runEn(runEn), .cpol(cpol),
    .sclk(sclk), .launchStb(launchStb), .latchStb(latchStb)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic writeWord(input int prof, input bit rst, input bit dbl,
                           input bit [1:0] junk, input int freq);
    @(negedge clk);
    cfgWe = 1'b1;
    cfgProfile = 2'(prof);
    cfgData = {rst, dbl, junk, 12'(freq)};
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // run n cycles, count strobes, report final sclk and bad samples
  task automatic runSeg(input int n, output int la, output int lt,
                        output int endSclk, output int bad);
    la = 0; lt = 0; bad = 0;
    runEn = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (launchStb) la++;
      if (latchStb)  lt++;
      if (launchStb && latchStb) bad++;
      if (launchStb && sclk == cpol) bad++;
      if (latchStb && sclk != cpol) bad++;
    end
    endSclk = sclk;
    runEn = 1'b0;
  endtask

  task automatic sweepPoint(input int s, input bit dbl, input bit pol);
    int la, lt, es, bad, eff, t, n;
    string tag;
    n = 400;
    eff = dbl ? 2 * s : s;
    if (eff > 1024) eff = 1024;
    t = (n * eff) / 1024;
    tag = dbl ? "R4" : ((s == 0 || s >= 1024) ? "R3" : "R2");
    writeWord(0, 1'b1, dbl, 2'b00, s);
    profSel = 2'd0;
    cpol = pol;
    runSeg(n, la, lt, es, bad);
    check(la == (t + 1) / 2, $sformatf("%s launch count step=%0d", tag, s), la, (t + 1) / 2);
    check(lt == t / 2, $sformatf("%s latch count step=%0d", tag, s), lt, t / 2);
    check(es == (pol ^ t[0]), $sformatf("R7 end level step=%0d", s), es, pol ^ t[0]);
    check(bad == 0, $sformatf("R8 strobe/level step=%0d", s), bad, 0);
    @(negedge clk);
    check(sclk == pol && !launchStb && !latchStb, "R6 stopped idle", sclk, pol);
  endtask

  initial begin
    int la, lt, es, bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check(sclk == 1'b0 && !launchStb && !latchStb, "R6 reset idle", sclk, 0);
    // all words reset to zero: running profile 3 gives nothing
    profSel = 2'd3;
    runSeg(50, la, lt, es, bad);
    check(la == 0 && lt == 0, "R1 reset word zero", la + lt, 0);

    // sweep of step values
    for (int s = 0; s <= 2100; s += 23) begin
      sweepPoint(s, 1'b0, s[0]);
      sweepPoint(s, 1'b1, ~s[0]);
    end
    sweepPoint(1024, 1'b0, 1'b1);
    sweepPoint(2048, 1'b0, 1'b0);
    sweepPoint(512, 1'b1, 1'b1);
    sweepPoint(1, 1'b0, 1'b0);

    // R1: bits 13:12 ignored; step 100 over 400 cycles -> 39 toggles
    writeWord(1, 1'b1, 1'b0, 2'b11, 100);
    profSel = 2'd1; cpol = 1'b0;
    runSeg(400, la, lt, es, bad);
    check(la == 20 && lt == 19, "R1 unused bits ignored", la * 100 + lt, 2019);

    // R5 / R9: profile 1 restarts, profile 2 continues
    writeWord(1, 1'b1, 1'b0, 2'b00, 300);
    writeWord(2, 1'b0, 1'b0, 2'b00, 300);
    profSel = 2'd1;
    runSeg(5, la, lt, es, bad);          // acc 1500, one toggle
    check(la == 1, "R5 first segment", la, 1);
    repeat (4) @(negedge clk);           // accumulator held while stopped
    profSel = 2'd2;
    runSeg(2, la, lt, es, bad);          // 1500 -> 2100 crosses 2048
    check(la == 1, "R5 continue from held value", la, 1);
    profSel = 2'd1;
    runSeg(2, la, lt, es, bad);          // 0 -> 600, no crossing
    check(la == 0 && lt == 0, "R5 restart from zero", la + lt, 0);
    // R9: switching to a zero-step profile mid-stream stops stepping
    writeWord(3, 1'b1, 1'b0, 2'b00, 0);
    profSel = 2'd3;
    runSeg(30, la, lt, es, bad);
    check(la == 0 && lt == 0 && es == cpol, "R9 profile select", la + lt, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule